// File: doc/BRIEF.md
# Coded-Ratio Reference Divider

This block turns a reference clock (from a crystal oscillator or an outside source) into the pulse train that feeds a phase comparator. The pulse period is set by a 5-bit select code. The upper two bits of the code pick a base factor, and the lower three bits pick a power-of-two multiplier. That gives 29 usable ratios between 2 and 448. Three codes have no ratio. Loading one of them keeps the ratio that is already in use and raises a sticky error flag. The next legal load clears the flag.

A new ratio is not used straight away. It is held as pending and takes over only when the running period reaches its terminal count. The period that is under way always finishes at its old length, so no short or stretched period appears on the comparison output.

The block also drives a shared reference/comparison output for a neighbouring synthesiser. This output can be switched off (it signals high impedance through an enable pin), or it can carry the raw reference clock or the comparison pulse train. Both control bits come out of reset set, so the comparison pulses appear on this output after power-up.

Top module: `refdiv_top`

## Requirements
- R1: For codes with bits [4:3] = 00, the comparison pulse period is 2 << code[2:0] reference cycles (codes 0..7 give 2 to 256).
- R2: For codes with bits [4:3] = g ≠ 00 and code[2:0] = k ≠ 0, the period is (4 + g) << (k − 1) cycles (5..320, 6..384, 7..448).
- R3: A load of code 01000, 10000 or 11000 leaves the period unchanged and sets codeErr; codeErr stays set until the next legal load.
- R4: A load with a legal code clears codeErr in the cycle after the load.
- R5: A new ratio takes effect only at a period boundary. The period running when the load occurs keeps its old length, and the following period uses the new ratio.
- R6: compPulse is high for exactly one reference cycle per period.
- R7: When the stored enable bit is 0, refCompOe is 0 and refCompOut is held at 0.
- R8: With enable = 1 and select = 0, refCompOut follows refClk.
- R9: With enable = 1 and select = 1, refCompOut follows compPulse.
- R10: After reset the enable and select bits are both 1, codeErr is 0, and the period is that of the reset code (default code 00000, period 2).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| refClk | input | 1 | Reference clock to be divided |
| rstN | input | 1 | Active-low asynchronous reset |
| cfgLoad | input | 1 | One-cycle strobe that captures the code and output controls |
| cfgCode | input | 5 | Ratio select code: [4:3] base group, [2:0] power-of-two step |
| cfgOutEn | input | 1 | Shared output enable bit to capture |
| cfgOutSel | input | 1 | Shared output source bit to capture: 0 reference, 1 comparison |
| compPulse | output | 1 | One-cycle pulse at the comparison rate |
| refCompOut | output | 1 | Shared reference/comparison output data |
| refCompOe | output | 1 | Drive enable for the shared output (0 means high impedance) |
| codeErr | output | 1 | Sticky flag, set when an illegal code was loaded |

## Verification
The hardest case to reach from the ports is a load that arrives partway through a period: the old ratio must finish before the new one applies. The stimulus makes this happen on purpose for every table entry. It waits for a comparison pulse, applies the load on the next falling edge, and then measures two intervals in a row. The first interval must match the old ratio and the second the new one. Illegal codes are placed right after large and small ratios, so a wrongly reloaded ratio would show up as an obvious change in the period.

// File: rtl/refdiv_pkg.sv
package refdiv_pkg;
  localparam int CODE_W    = 5;
  localparam int STEP_W    = 3;
  localparam int GRP_W     = CODE_W - STEP_W;
  localparam int MAX_RATIO = 7 << ((1 << STEP_W) - 2);
  localparam int RATIO_W   = $clog2(MAX_RATIO + 1);

  typedef logic [RATIO_W-1:0] ratio_t;
  typedef logic [CODE_W-1:0]  code_t;

  typedef struct packed {
    logic   legal;
    ratio_t ratio;
  } decode_t;

  typedef struct packed {
    logic   applyRatio;
    ratio_t nextRatio;
  } divStrobe_t;

  // Base factor 2 (group 0) or 4+group, scaled by a power of two.
  function automatic decode_t decodeCode(input code_t code);
    decode_t            d;
    logic [GRP_W-1:0]   grp;
    logic [STEP_W-1:0]  step;
    grp  = code[CODE_W-1:STEP_W];
    step = code[STEP_W-1:0];
    d.legal = 1'b1;
    if (grp == '0) begin
      d.ratio = ratio_t'(2) << step;
    end else if (step == '0) begin
      d.legal = 1'b0;
      d.ratio = '0;
    end else begin
      d.ratio = ratio_t'({1'b1, grp}) << (step - 1'b1);
    end
    return d;
  endfunction
endpackage

// File: rtl/refdiv_ctrl.sv
module refdiv_ctrl
  import refdiv_pkg::*;
#(
  parameter code_t RESET_CODE = '0
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       cfgLoad,
  input  code_t      cfgCode,
  input  logic       cfgOutEn,
  input  logic       cfgOutSel,
  input  logic       termCount,
  output divStrobe_t strb,
  output logic       outEn,
  output logic       outSel,
  output logic       codeErr
);
  localparam decode_t RESET_DEC = decodeCode(RESET_CODE);

  decode_t loadDec;
  ratio_t  pendRatio;
  logic    pendValid;

  assign loadDec = decodeCode(cfgCode);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outEn     <= 1'b1;
      outSel    <= 1'b1;
      codeErr   <= 1'b0;
      pendValid <= 1'b0;
      pendRatio <= RESET_DEC.ratio;
    end else begin
      if (termCount) pendValid <= 1'b0;
      if (cfgLoad) begin
        outEn  <= cfgOutEn;
        outSel <= cfgOutSel;
        if (loadDec.legal) begin
          pendRatio <= loadDec.ratio;
          pendValid <= 1'b1;
          codeErr   <= 1'b0;
        end else begin
          codeErr <= 1'b1;
        end
      end
    end
  end

  always_comb begin
    strb.applyRatio = pendValid & termCount;
    strb.nextRatio  = pendRatio;
  end
endmodule

// File: rtl/refdiv_datapath.sv
module refdiv_datapath
  import refdiv_pkg::*;
#(
  parameter ratio_t RESET_RATIO = ratio_t'(2)
) (
  input  logic       clk,
  input  logic       rstN,
  input  divStrobe_t strb,
  output logic       termCount,
  output logic       compPulse
);
  ratio_t cnt;
  ratio_t activeRatio;

  assign termCount = (cnt == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt         <= '0;
      activeRatio <= RESET_RATIO;
      compPulse   <= 1'b0;
    end else begin
      compPulse <= termCount;
      if (termCount) begin
        if (strb.applyRatio) begin
          activeRatio <= strb.nextRatio;
          cnt         <= strb.nextRatio - ratio_t'(1);
        end else begin
          cnt <= activeRatio - ratio_t'(1);
        end
      end else begin
        cnt <= cnt - ratio_t'(1);
      end
    end
  end
endmodule

// File: rtl/refdiv_top.sv
module refdiv_top
  import refdiv_pkg::*;
#(
  parameter code_t RESET_CODE = '0
) (
  input  logic              refClk,
  input  logic              rstN,
  input  logic              cfgLoad,
  input  logic [CODE_W-1:0] cfgCode,
  input  logic              cfgOutEn,
  input  logic              cfgOutSel,
  output logic              compPulse,
  output logic              refCompOut,
  output logic              refCompOe,
  output logic              codeErr
);
  localparam decode_t RESET_DEC = decodeCode(RESET_CODE);

  divStrobe_t strb;
  logic       termCount;
  logic       outEn;
  logic       outSel;

  refdiv_ctrl #(.RESET_CODE(RESET_CODE)) i_ctrl (
    .clk      (refClk),
    .rstN     (rstN),
    .cfgLoad  (cfgLoad),
    .cfgCode  (cfgCode),
    .cfgOutEn (cfgOutEn),
    .cfgOutSel(cfgOutSel),
    .termCount(termCount),
    .strb     (strb),
    .outEn    (outEn),
    .outSel   (outSel),
    .codeErr  (codeErr)
  );

  refdiv_datapath #(.RESET_RATIO(RESET_DEC.ratio)) i_dp (
    .clk      (refClk),
    .rstN     (rstN),
    .strb     (strb),
    .termCount(termCount),
    .compPulse(compPulse)
  );

  assign refCompOe  = outEn;
  assign refCompOut = outEn & (outSel ? compPulse : refClk);
endmodule

// File: rtl/refdiv_chk.sv
module refdiv_chk
  import refdiv_pkg::*;
(
  input logic        refClk,
  input logic        rstN,
  input logic        cfgLoad,
  input logic [4:0]  cfgCode,
  input logic        cfgOutEn,
  input logic        compPulse,
  input logic        refCompOe,
  input logic        codeErr
);
  logic illegalIn;
  int   gapCnt;

  assign illegalIn = (cfgCode[4:3] != 2'b00) && (cfgCode[2:0] == 3'b000);

  always_ff @(posedge refClk or negedge rstN) begin
    if (!rstN)          gapCnt <= 0;
    else if (compPulse) gapCnt <= 1;
    else if (gapCnt <= MAX_RATIO) gapCnt <= gapCnt + 1;
  end

  // R6
  pulse_single_chk: assert property (@(posedge refClk) disable iff (!rstN)
    compPulse |=> !compPulse);

  // R6
  pulse_gap_chk: assert property (@(posedge refClk) disable iff (!rstN)
    compPulse |-> gapCnt <= MAX_RATIO);

  // R3
  illegal_flag_chk: assert property (@(posedge refClk) disable iff (!rstN)
    cfgLoad && illegalIn |=> codeErr);

  // R3
  flag_hold_chk: assert property (@(posedge refClk) disable iff (!rstN)
    codeErr && !cfgLoad |=> codeErr);

  // R4
  legal_clear_chk: assert property (@(posedge refClk) disable iff (!rstN)
    cfgLoad && !illegalIn |=> !codeErr);

  // R7
  oe_off_chk: assert property (@(posedge refClk) disable iff (!rstN)
    cfgLoad && !cfgOutEn |=> !refCompOe);
endmodule

bind refdiv_top refdiv_chk i_chk (
  .refClk   (refClk),
  .rstN     (rstN),
  .cfgLoad  (cfgLoad),
  .cfgCode  (cfgCode),
  .cfgOutEn (cfgOutEn),
  .compPulse(compPulse),
  .refCompOe(refCompOe),
  .codeErr  (codeErr)
);

// File: tb/test_refdiv_top.sv
module test_refdiv_top;
  typedef struct packed {
    logic [4:0] code;
    logic [8:0] ratio;
    logic       err;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VECS [NV] = '{
    '{5'b00000, 9'd2,   1'b0},
    '{5'b00111, 9'd256, 1'b0},
    '{5'b00011, 9'd16,  1'b0},
    '{5'b01001, 9'd5,   1'b0},
    '{5'b01111, 9'd320, 1'b0},
    '{5'b10001, 9'd6,   1'b0},
    '{5'b10101, 9'd96,  1'b0},
    '{5'b11010, 9'd14,  1'b0},
    '{5'b11111, 9'd448, 1'b0},
    '{5'b01000, 9'd448, 1'b1},
    '{5'b10000, 9'd448, 1'b1},
    '{5'b11001, 9'd7,   1'b0},
    '{5'b11000, 9'd7,   1'b1},
    '{5'b00101, 9'd64,  1'b0}
  };

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       cfgLoad = 1'b0;
  logic [4:0] cfgCode = '0;
  logic       cfgOutEn = 1'b1;
  logic       cfgOutSel = 1'b1;
  logic       compPulse, refCompOut, refCompOe, codeErr;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  refdiv_top i_refdiv_top (
    .refClk    (clk),
    .rstN      (rstN),
    .cfgLoad   (cfgLoad),
    .cfgCode   (cfgCode),
    .cfgOutEn  (cfgOutEn),
    .cfgOutSel (cfgOutSel),
    .compPulse (compPulse),
    .refCompOut(refCompOut),
    .refCompOe (refCompOe),
    .codeErr   (codeErr)
  );

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic syncPulse();
    do @(negedge clk); while (!compPulse);
  endtask

  task automatic measure(output int n);
    n = 0;
    do begin @(negedge clk); n++; end while (!compPulse);
  endtask

  task automatic loadThenMeasure(input logic [4:0] code, input logic oe,
                                 input logic sel, output int n);
    cfgCode = code; cfgOutEn = oe; cfgOutSel = sel; cfgLoad = 1'b1;
    @(negedge clk);
    cfgLoad = 1'b0;
    n = 1;
    while (!compPulse) begin @(negedge clk); n++; end
  endtask

  initial begin
    int prev, oldI, newI;
    repeat (3) @(negedge clk);
    // R10 reset state
    check(refCompOe == 1'b1, "R10", "oe in reset", refCompOe, 1);
    check(codeErr == 1'b0, "R10", "codeErr in reset", codeErr, 0);
    check(compPulse == 1'b0, "R10", "pulse in reset", compPulse, 0);
    rstN = 1'b1;
    syncPulse();
    measure(newI);
    check(newI == 2, "R10", "period after reset", newI, 2);
    check(refCompOut == compPulse, "R9", "out follows pulse after reset", refCompOut, compPulse);

    prev = 2;
    for (int i = 0; i < NV; i++) begin
      string tag;
      syncPulse();
      loadThenMeasure(VECS[i].code, 1'b1, 1'b1, oldI);
      measure(newI);
      if (VECS[i].err) tag = "R3";
      else if (VECS[i].code[4:3] == 2'b00) tag = "R1";
      else tag = "R2";
      check(oldI == prev, "R5", "interval after load", oldI, prev);
      check(newI == int'(VECS[i].ratio), tag, "new period", newI, VECS[i].ratio);
      check(codeErr == VECS[i].err, VECS[i].err ? "R3" : "R4", "codeErr",
            codeErr, VECS[i].err);
      @(negedge clk);
      check(compPulse == 1'b0, "R6", "pulse width", compPulse, 0);
      prev = VECS[i].ratio;
    end

    // R8 reference selected
    syncPulse();
    loadThenMeasure(5'b00101, 1'b1, 1'b0, oldI);
    check(oldI == 64, "R5", "same-code reload period", oldI, 64);
    check(refCompOut == 1'b0, "R8", "out low phase", refCompOut, 0);
    @(posedge clk); #2;
    check(refCompOut == 1'b1, "R8", "out high phase", refCompOut, 1);

    // R7 output disabled
    syncPulse();
    loadThenMeasure(5'b00101, 1'b0, 1'b1, oldI);
    check(refCompOe == 1'b0, "R7", "oe off", refCompOe, 0);
    check(refCompOut == 1'b0, "R7", "out quiet on pulse", refCompOut, 0);
    @(posedge clk); #2;
    check(refCompOut == 1'b0, "R7", "out quiet high phase", refCompOut, 0);

    // R9 comparison selected
    syncPulse();
    loadThenMeasure(5'b00101, 1'b1, 1'b1, oldI);
    check(refCompOut == 1'b1, "R9", "out on pulse", refCompOut, 1);
    @(negedge clk);
    check(refCompOut == 1'b0, "R9", "out between pulses", refCompOut, 0);
    @(posedge clk); #2;
    check(refCompOut == 1'b0, "R9", "out ignores refClk", refCompOut, 0);

    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 200000, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule